// File: doc/BRIEF.md
# Display DMA Channel Control with Shadow Register Reload

This block is the register and sequencing logic for one display DMA channel. Software programs a transfer description (element count, frame count and a 32-bit base address) into a shadow set. It then sets a load request flag. The block copies the shadow set into the active set that the address generator uses. The copy happens only while the channel is idle, or at the boundary between two blocks. It never happens while a block is in flight.

A running channel issues a one-cycle start pulse to the address generator, which later answers with a block-done pulse. Each completed block latches a status flag, which can raise an interrupt. When both auto-reload and repeat are selected, the channel starts the next block by itself and takes up any pending shadow set on the way. Otherwise the enable bit clears itself and the channel stops. Software can stop the channel early in three ways: clearing the enable bit, clearing the external-controller enable, or releasing the channel claim.

Top module: `dispdma_chan`

## Requirements
- R1: After reset, every register reads 0 and `busy`, `startPulse` and `irq` are 0.
- R2: The register map is as follows. Offset 0 is the channel control register: bit 0 claim, bit 7 enable, bit 8 auto-reload, bit 9 repeat, bit 11 load request, bits 13:12 index mode. Offset 1 is the auxiliary register: bit 1 interrupt enable, bit 3 block status, bit 8 external-controller enable. Offsets 2 and 3 hold the shadow element and frame counts. Offsets 4 and 5 hold the low and high words of the shadow base. Unlisted bits read 0.
- R3: The channel starts when it is idle and claim, enable and external-controller enable are all 1. In the cycle after those register values take effect, `busy` rises and `startPulse` is high for exactly one cycle.
- R4: While the channel is idle, a set load request copies the shadow set into the active outputs. The request bit then reads 0, one cycle after the write lands.
- R5: While a block is in flight, the active outputs do not change, whatever is written to the shadow set or the load request bit.
- R6: A block-done pulse while busy sets the status bit in the same cycle the pulse is sampled. A block-done pulse while idle has no effect.
- R7: With auto-reload and repeat both 1, block-done gives a fresh `startPulse` in the next cycle. `busy` and enable stay 1, and a pending load request is copied and cleared at that boundary.
- R8: If auto-reload or repeat is 0, block-done clears the enable bit and drops `busy`, with no `startPulse`.
- R9: `irq` is high exactly when the status bit and the interrupt enable are both 1.
- R10: Writing 1 to the status bit clears it and writing 0 leaves it. A block-done in the same cycle as a clearing write leaves the status set.
- R11: Clearing enable or external-controller enable while busy drops `busy` in the next cycle without setting status.
- R12: With claim 0 the enable bit is forced to 0, so enable writes are ignored. Releasing the claim while busy stops the channel in the next cycle.
- R13: `dblIndex` is 1 exactly when both index mode bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write offset |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | ADDR_W | Register read offset |
| rdData | output | DATA_W | Combinational read data |
| blkDone | input | 1 | Block-complete pulse from the address generator |
| startPulse | output | 1 | One-cycle block start to the address generator |
| busy | output | 1 | A block is in flight |
| actElem | output | DATA_W | Active element count |
| actFrame | output | DATA_W | Active frame count |
| actBase | output | 2*DATA_W | Active base address |
| dblIndex | output | 1 | Double-indexed addressing selected |
| irq | output | 1 | Block-complete interrupt |

## Verification
Register writes and block-done pulses show up at the ports in the first cycle after the edge that samples them: read data, status, `irq`, the self-cleared enable and a restart pulse. A start from idle, an abort and an idle-time shadow copy need one more edge, because the sequencer reacts to register values that have already landed. The bench drives inputs and checks them 1 ns after the falling edge. Effects due one cycle later go into a queue tagged with their due cycle. A monitor compares them on the falling edge of exactly that cycle, and it counts any item left unchecked as a mismatch.

// File: rtl/dispdma_pkg.sv
package dispdma_pkg;
  localparam logic [2:0] ADR_CHAN    = 3'd0;
  localparam logic [2:0] ADR_AUX     = 3'd1;
  localparam logic [2:0] ADR_ELEM    = 3'd2;
  localparam logic [2:0] ADR_FRAME   = 3'd3;
  localparam logic [2:0] ADR_BASE_LO = 3'd4;

  localparam int CH_CLAIM   = 0;
  localparam int CH_EN      = 7;
  localparam int CH_AUTO    = 8;
  localparam int CH_RPT     = 9;
  localparam int CH_LOADREQ = 11;
  localparam int CH_IDX_LO  = 12;

  localparam int AX_IRQEN = 1;
  localparam int AX_STAT  = 3;
  localparam int AX_EXT   = 8;

  typedef struct packed {
    logic copySet;
  } ctlStrobe_t;
endpackage

// File: rtl/dispdma_ctrl.sv
module dispdma_ctrl
  import dispdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              blkDone,
  output ctlStrobe_t        strb,
  output logic [DATA_W-1:0] chanVal,
  output logic [DATA_W-1:0] auxVal,
  output logic              startPulse,
  output logic              busy,
  output logic              irq,
  output logic              dblIndex
);
  logic claim, enable, autoInit, rpt, loadReq;
  logic [1:0] idxMode;
  logic irqEn, status, extEn;
  logic run;
  logic chanWr, auxWr, runOk, doneEvt, restart, stopSelf, abortNow, startNow, copyNow;

  always_comb begin
    chanWr   = wrEn && (wrAddr == ADDR_W'(ADR_CHAN));
    auxWr    = wrEn && (wrAddr == ADDR_W'(ADR_AUX));
    runOk    = claim && enable && extEn;
    doneEvt  = run && runOk && blkDone;
    restart  = doneEvt && autoInit && rpt;
    stopSelf = doneEvt && !(autoInit && rpt);
    abortNow = run && !runOk;
    startNow = (!run && runOk) || restart;
    copyNow  = loadReq && (!run || restart);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      claim <= 1'b0; enable <= 1'b0; autoInit <= 1'b0; rpt <= 1'b0;
      loadReq <= 1'b0; idxMode <= 2'b00;
      irqEn <= 1'b0; status <= 1'b0; extEn <= 1'b0;
      run <= 1'b0; startPulse <= 1'b0;
    end else begin
      if (!run && runOk) run <= 1'b1;
      else if (abortNow || stopSelf) run <= 1'b0;
      startPulse <= startNow;
      if (chanWr) begin
        claim    <= wrData[CH_CLAIM];
        enable   <= wrData[CH_EN] & wrData[CH_CLAIM];
        autoInit <= wrData[CH_AUTO];
        rpt      <= wrData[CH_RPT];
        loadReq  <= wrData[CH_LOADREQ];
        idxMode  <= wrData[CH_IDX_LO +: 2];
      end else begin
        if (copyNow) loadReq <= 1'b0;
        if (stopSelf) enable <= 1'b0;
      end
      if (auxWr) begin
        irqEn <= wrData[AX_IRQEN];
        extEn <= wrData[AX_EXT];
      end
      if (doneEvt) status <= 1'b1;
      else if (auxWr && wrData[AX_STAT]) status <= 1'b0;
    end
  end

  always_comb begin
    chanVal = '0;
    chanVal[CH_CLAIM]         = claim;
    chanVal[CH_EN]            = enable;
    chanVal[CH_AUTO]          = autoInit;
    chanVal[CH_RPT]           = rpt;
    chanVal[CH_LOADREQ]       = loadReq;
    chanVal[CH_IDX_LO +: 2]   = idxMode;
    auxVal = '0;
    auxVal[AX_IRQEN] = irqEn;
    auxVal[AX_STAT]  = status;
    auxVal[AX_EXT]   = extEn;
  end

  assign strb.copySet = copyNow;
  assign busy         = run;
  assign irq          = status && irqEn;
  assign dblIndex     = &idxMode;

  AST_COPY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strb.copySet |-> (!busy || blkDone)); // R5
  AST_START_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(claim && extEn)); // R12
  AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runOk && blkDone) |=> status); // R6
  AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (busy && runOk && blkDone && !(autoInit && rpt) && !chanWr) |=> (!enable && !busy)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> irqEn); // R9
endmodule

// File: rtl/dispdma_regs.sv
module dispdma_regs
  import dispdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  ctlStrobe_t          strb,
  input  logic [DATA_W-1:0]   chanVal,
  input  logic [DATA_W-1:0]   auxVal,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic [DATA_W-1:0]   actElem,
  output logic [DATA_W-1:0]   actFrame,
  output logic [2*DATA_W-1:0] actBase
);
  localparam int BASE_WORDS = 2;
  localparam int BASE_W     = BASE_WORDS * DATA_W;

  logic [DATA_W-1:0] progElem, progFrame;
  logic [BASE_W-1:0] progBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progElem  <= '0;
      progFrame <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADR_ELEM))  progElem  <= wrData;
      if (wrAddr == ADDR_W'(ADR_FRAME)) progFrame <= wrData;
    end
  end

  for (genvar w = 0; w < BASE_WORDS; w++) begin : g_baseWord
    always_ff @(posedge clk) begin
      if (!rstN) progBase[w*DATA_W +: DATA_W] <= '0;
      else if (wrEn && wrAddr == ADDR_W'(ADR_BASE_LO + w))
        progBase[w*DATA_W +: DATA_W] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actElem  <= '0;
      actFrame <= '0;
      actBase  <= '0;
    end else if (strb.copySet) begin
      actElem  <= progElem;
      actFrame <= progFrame;
      actBase  <= progBase;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(ADR_CHAN))       rdData = chanVal;
    else if (rdAddr == ADDR_W'(ADR_AUX))   rdData = auxVal;
    else if (rdAddr == ADDR_W'(ADR_ELEM))  rdData = progElem;
    else if (rdAddr == ADDR_W'(ADR_FRAME)) rdData = progFrame;
    else begin
      for (int w = 0; w < BASE_WORDS; w++)
        if (rdAddr == ADDR_W'(ADR_BASE_LO + w)) rdData = progBase[w*DATA_W +: DATA_W];
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.copySet |=> $stable({actElem, actFrame, actBase})); // R5
endmodule

// File: rtl/dispdma_chan.sv
module dispdma_chan
  import dispdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                blkDone,
  output logic                startPulse,
  output logic                busy,
  output logic [DATA_W-1:0]   actElem,
  output logic [DATA_W-1:0]   actFrame,
  output logic [2*DATA_W-1:0] actBase,
  output logic                dblIndex,
  output logic                irq
);
  ctlStrobe_t        strb;
  logic [DATA_W-1:0] chanVal, auxVal;

  dispdma_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .blkDone(blkDone), .strb(strb), .chanVal(chanVal), .auxVal(auxVal),
    .startPulse(startPulse), .busy(busy), .irq(irq), .dblIndex(dblIndex)
  );

  dispdma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .chanVal(chanVal), .auxVal(auxVal), .rdAddr(rdAddr),
    .rdData(rdData), .actElem(actElem), .actFrame(actFrame), .actBase(actBase)
  );
endmodule

// File: tb/tb_dispdma_chan.sv
`timescale 1ns/1ps
module tb_dispdma_chan;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int K_BUSY = 0, K_START = 1, K_ELEM = 2, K_BASE = 3, K_CHAN = 4, K_AUX = 5;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, blkDone = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0, rdData, actElem, actFrame;
  logic [2*DW-1:0] actBase;
  logic startPulse, busy, dblIndex, irq;

  dispdma_chan dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .blkDone(blkDone), .startPulse(startPulse),
    .busy(busy), .actElem(actElem), .actFrame(actFrame), .actBase(actBase),
    .dblIndex(dblIndex), .irq(irq)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  int nCmp = 0, nBad = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; logic [31:0] val; string req; } exp_t;
  exp_t q[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pushExp(int due, int kind, logic [31:0] val, string req);
    exp_t e;
    e.due = due; e.kind = kind; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  function automatic logic [31:0] observe(int kind);
    case (kind)
      K_BUSY:  return {31'd0, busy};
      K_START: return {31'd0, startPulse};
      K_ELEM:  return {16'd0, actElem};
      default: return actBase;
    endcase
  endfunction

  // monitor: compares queued expectations in their due cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        chk(q[i].req, $sformatf("kind%0d@%0d", q[i].kind, cyc), observe(q[i].kind), q[i].val);
        q.delete(i);
      end else if (q[i].due < cyc) begin
        chk(q[i].req, "stale expectation", 32'd1, 32'd0);
        q.delete(i);
      end
    end
  end

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic chkReg(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    logic [DW-1:0] d;
    rd(a, d);
    chk(req, $sformatf("reg%0d", a), {16'd0, d}, {16'd0, exp});
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); #1;
    blkDone = 1'b1;
    @(negedge clk); #1;
    blkDone = 1'b0;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "startPulse", {31'd0, startPulse}, 0);
    chk("R1", "irq", {31'd0, irq}, 0);
    for (int a = 0; a < 6; a++) chkReg("R1", AW'(a), 16'h0000);

    // R2 shadow set programming and readback
    wr(3'd2, 16'h0140); wr(3'd3, 16'h00F0); wr(3'd4, 16'h1000); wr(3'd5, 16'h8000);
    chkReg("R2", 3'd2, 16'h0140); chkReg("R2", 3'd3, 16'h00F0);
    chkReg("R2", 3'd4, 16'h1000); chkReg("R2", 3'd5, 16'h8000);
    chk("R4", "active untouched without load request", {16'd0, actElem}, 0);
    wr(3'd1, 16'hFFF6);
    chkReg("R2", 3'd1, 16'h0102);

    // R3/R4 single-shot start with load request
    wr(3'd0, 16'h0881);
    chkReg("R2", 3'd0, 16'h0881);
    pushExp(cyc + 1, K_BUSY, 1, "R3");
    pushExp(cyc + 1, K_START, 1, "R3");
    pushExp(cyc + 1, K_ELEM, 32'h0140, "R4");
    pushExp(cyc + 1, K_BASE, 32'h80001000, "R4");
    pushExp(cyc + 2, K_START, 0, "R3");
    @(negedge clk); #1;
    chkReg("R4", 3'd0, 16'h0081);
    chk("R13", "dblIndex off", {31'd0, dblIndex}, 0);

    // R5 shadow write during a block does not reach active
    wr(3'd2, 16'h0200);
    @(negedge clk); #1;
    chk("R5", "actElem held", {16'd0, actElem}, 32'h0140);

    // R6/R8/R9 block done, single mode
    pulseDone();
    chk("R6", "status via irq", {31'd0, irq}, 1);
    chkReg("R6", 3'd1, 16'h010A);
    chk("R8", "busy dropped", {31'd0, busy}, 0);
    chk("R8", "no restart", {31'd0, startPulse}, 0);
    chkReg("R8", 3'd0, 16'h0001);

    // R10 write-one-to-clear
    wr(3'd1, 16'h0102);
    chkReg("R10", 3'd1, 16'h010A);
    wr(3'd1, 16'h010A);
    chkReg("R10", 3'd1, 16'h0102);
    chk("R9", "irq low after clear", {31'd0, irq}, 0);

    // R6 block done while idle ignored
    pulseDone();
    chkReg("R6", 3'd1, 16'h0102);
    chk("R6", "busy stays idle", {31'd0, busy}, 0);

    // R7/R13 repeat mode with double index
    wr(3'd0, 16'h3B81);
    chk("R13", "dblIndex on", {31'd0, dblIndex}, 1);
    pushExp(cyc + 1, K_START, 1, "R3");
    pushExp(cyc + 1, K_ELEM, 32'h0200, "R4");
    @(negedge clk); #1;
    wr(3'd2, 16'h0300);
    wr(3'd0, 16'h3B81);
    @(negedge clk); #1;
    chk("R5", "pending load waits for boundary", {16'd0, actElem}, 32'h0200);
    chkReg("R5", 3'd0, 16'h3B81);
    pulseDone();
    chk("R7", "restart pulse", {31'd0, startPulse}, 1);
    chk("R7", "busy kept", {31'd0, busy}, 1);
    chk("R7", "copy at boundary", {16'd0, actElem}, 32'h0300);
    chkReg("R7", 3'd0, 16'h3381);
    pushExp(cyc + 1, K_START, 0, "R7");
    @(negedge clk); #1;
    pulseDone();
    chk("R7", "second restart", {31'd0, startPulse}, 1);

    // R10 set wins over clear in same cycle
    @(negedge clk); #1;
    blkDone = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 16'h010A;
    @(negedge clk); #1;
    blkDone = 1'b0; wrEn = 1'b0;
    chkReg("R10", 3'd1, 16'h010A);

    // R11 abort via external enable
    wr(3'd1, 16'h010A);
    wr(3'd1, 16'h0002);
    pushExp(cyc + 1, K_BUSY, 0, "R11");
    @(negedge clk); #1;
    chkReg("R11", 3'd1, 16'h0002);
    chkReg("R11", 3'd0, 16'h3381);

    // R3 restart from idle when external enable returns
    wr(3'd1, 16'h0102);
    pushExp(cyc + 1, K_BUSY, 1, "R3");
    pushExp(cyc + 1, K_START, 1, "R3");
    @(negedge clk); #1;

    // R12 release claim while busy
    wr(3'd0, 16'h0080);
    chkReg("R12", 3'd0, 16'h0000);
    pushExp(cyc + 1, K_BUSY, 0, "R12");
    @(negedge clk); #1;
    wr(3'd0, 16'h0080);
    chkReg("R12", 3'd0, 16'h0000);
    pushExp(cyc + 1, K_BUSY, 0, "R12");
    pushExp(cyc + 1, K_START, 0, "R12");
    repeat (3) @(negedge clk);
    #1;
    if (q.size() != 0) chk("R3", "queue drained", q.size(), 0);
    chkReg("R1", 3'd7, 16'h0000);
    finishRun();
  end
endmodule